// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns a 32-bit program counter and, on every clock edge where it is not stalled, replaces it with the address of the next instruction. It decodes the class of the current instruction word on its own (sequential, conditional branch, absolute jump, or jump through a register), compares the two branch operands for equality, builds the branch and jump targets, and selects one of them.

A branch target is the address of the following instruction plus the 16-bit signed offset scaled to words. An absolute jump keeps the region bits at the top of the current PC and inserts a 26-bit word index below them. A register jump takes a full 32-bit value supplied by the surrounding pipeline. The incremented PC is always available as a link address, and a combinational flag reports whether the present branch is taken. All pins are plain control and data signals; no stream handshake is involved, and the only form of back-pressure is the stall input, which freezes the PC.

Top module: `pc_nextaddr`

## Requirements
- R1: A synchronous active-high reset loads the PC with the reset vector (default 0x00400000); reset takes priority over stall.
- R2: An opcode (bits [31:26]) that is not 0, 2, 3, 4 or 5, or opcode 0 with a function code (bits [5:0]) other than 8, advances the PC by 4.
- R3: The link output always equals the current PC plus 4.
- R4: Opcode 4 (branch if equal) with equal operands loads (PC + 4) + sign-extended bits [15:0] times 4; with unequal operands the PC advances by 4.
- R5: Opcode 5 (branch if not equal) with unequal operands loads the same branch target; with equal operands the PC advances by 4.
- R6: The branch offset is two's complement, so 0xFFFE steps back two words and 0x8000 steps back 2^15 words from PC + 4.
- R7: Opcodes 2 and 3 load {PC[31:28], bits [25:0], 2'b00}; for opcode 3 the link output carries PC + 4 in the same cycle.
- R8: Opcode 0 with function code 8 loads the register-jump value input unchanged.
- R9: While stall is high and reset is low, the PC keeps its value regardless of the instruction.
- R10: The branch-taken flag is combinational, high only for opcode 4 or 5 whose compare holds, and low for every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold the PC when high |
| instr_i | input | 32 | Current instruction word |
| cmp_a_i | input | 32 | First branch compare operand (rs value) |
| cmp_b_i | input | 32 | Second branch compare operand (rt value) |
| jreg_i | input | 32 | Target for a jump through a register |
| pc_o | output | 32 | Current program counter |
| pc_plus4_o | output | 32 | Current PC plus 4 (link address) |
| br_taken_o | output | 1 | Current branch is taken |

## Verification
The link output and branch-taken flag are combinational, so they are due in the same cycle the instruction and operands are presented; the bench checks them one nanosecond after driving inputs on the falling edge. The new PC is due after exactly one rising edge: the driver pushes the expected address into a queue when it drives a stimulus, and a monitor pops it on the next falling edge, half a cycle after the register has updated. Stalled and reset cycles push an expected value too, so the one-edge latency is checked for every cycle.

// File: rtl/pcnext_pkg.sv
package pcnext_pkg;
  typedef enum logic [1:0] {
    NX_SEQ    = 2'd0,
    NX_BRANCH = 2'd1,
    NX_JUMP   = 2'd2,
    NX_REG    = 2'd3
  } nx_kind_e;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OP_JMPLINK = 6'd3;
  localparam logic [OP_W-1:0] OP_BREQ    = 6'd4;
  localparam logic [OP_W-1:0] OP_BRNE    = 6'd5;
  localparam logic [FN_W-1:0] FN_REGJMP  = 6'd8;
endpackage

// File: rtl/pcnext_decode.sv
module pcnext_decode
  import pcnext_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic [FN_W-1:0] funct_i,
  input  logic [XLEN-1:0] cmp_a_i,
  input  logic [XLEN-1:0] cmp_b_i,
  output nx_kind_e        kind_o,
  output logic            taken_o
);
  logic same;
  assign same = (cmp_a_i == cmp_b_i);

  always_comb begin
    kind_o  = NX_SEQ;
    taken_o = 1'b0;
    case (opcode_i)
      OP_BREQ: begin
        kind_o  = NX_BRANCH;
        taken_o = same;
      end
      OP_BRNE: begin
        kind_o  = NX_BRANCH;
        taken_o = !same;
      end
      OP_JMP, OP_JMPLINK: kind_o = NX_JUMP;
      OP_SPECIAL: if (funct_i == FN_REGJMP) kind_o = NX_REG;
      default: kind_o = NX_SEQ;
    endcase
  end
endmodule

// File: rtl/pcnext_target.sv
module pcnext_target #(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int JIDX_W = 26,
  parameter int SHIFT  = 2
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   seq_o,
  output logic [XLEN-1:0]   br_o,
  output logic [XLEN-1:0]   jmp_o
);
  localparam int REGION_W = XLEN - JIDX_W - SHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << SHIFT;

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  imm_sext;

  assign imm      = jidx_i[IMM_W-1:0];
  assign imm_sext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign seq_o    = pc_i + STEP;
  assign br_o     = seq_o + (imm_sext << SHIFT);
  assign jmp_o    = {pc_i[XLEN-1 -: REGION_W], jidx_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/pc_nextaddr.sv
module pc_nextaddr
  import pcnext_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] cmp_a_i,
  input  logic [XLEN-1:0] cmp_b_i,
  input  logic [XLEN-1:0] jreg_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] pc_plus4_o,
  output logic            br_taken_o
);
  localparam int JIDX_W   = 26;
  localparam int SHIFT    = 2;
  localparam int REGION_W = XLEN - JIDX_W - SHIFT;

  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] seq_addr, br_addr, jmp_addr;
  nx_kind_e        kind;
  logic            taken;

  pcnext_decode #(.XLEN(XLEN)) u_decode (
    .opcode_i (instr_i[XLEN-1 -: OP_W]),
    .funct_i  (instr_i[FN_W-1:0]),
    .cmp_a_i  (cmp_a_i),
    .cmp_b_i  (cmp_b_i),
    .kind_o   (kind),
    .taken_o  (taken)
  );

  pcnext_target #(.XLEN(XLEN), .IMM_W(16), .JIDX_W(JIDX_W), .SHIFT(SHIFT)) u_target (
    .pc_i   (pc_q),
    .jidx_i (instr_i[JIDX_W-1:0]),
    .seq_o  (seq_addr),
    .br_o   (br_addr),
    .jmp_o  (jmp_addr)
  );

  always_comb begin
    case (kind)
      NX_BRANCH: pc_d = taken ? br_addr : seq_addr;
      NX_JUMP:   pc_d = jmp_addr;
      NX_REG:    pc_d = jreg_i;
      default:   pc_d = seq_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           pc_q <= RESET_VEC;
    else if (!stall_i) pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign pc_plus4_o = seq_addr;
  assign br_taken_o = taken;

  assert_reset_vec_R1: assert property (@(posedge clk)
    rst |=> pc_q == RESET_VEC);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> pc_q == $past(pc_q));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && kind == NX_SEQ) |=> pc_q == $past(pc_q) + 32'd4);

  assert_untaken_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && kind == NX_BRANCH && !br_taken_o) |=> pc_q == $past(pc_q) + 32'd4);

  assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && kind == NX_JUMP) |=>
      (pc_q[XLEN-1 -: REGION_W] == $past(pc_q[XLEN-1 -: REGION_W]) && pc_q[SHIFT-1:0] == '0));

  assert_regjump_R8: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && kind == NX_REG) |=> pc_q == $past(jreg_i));

  assert_taken_branch_R10: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> kind == NX_BRANCH);
endmodule

// File: tb/pc_nextaddr_bench.sv
module pc_nextaddr_bench;
  localparam logic [31:0] RV = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic [31:0] instr_i = '0, cmp_a_i = '0, cmp_b_i = '0, jreg_i = '0;
  logic [31:0] pc_o, pc_plus4_o;
  logic        br_taken_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mpc;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  pc_nextaddr u_pc_nextaddr (
    .clk(clk), .rst(rst), .stall_i(stall_i), .instr_i(instr_i),
    .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .jreg_i(jreg_i),
    .pc_o(pc_o), .pc_plus4_o(pc_plus4_o), .br_taken_o(br_taken_o)
  );

  function automatic logic exp_taken(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    return (ins[31:26] == 6'd4 && a == b) || (ins[31:26] == 6'd5 && a != b);
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] pc, logic [31:0] ins,
                                             logic [31:0] a, logic [31:0] b, logic [31:0] jr);
    logic [31:0] off;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    if (exp_taken(ins, a, b))                          return pc + 32'd4 + off;
    if (ins[31:26] == 6'd2 || ins[31:26] == 6'd3)      return {pc[31:28], ins[25:0], 2'b00};
    if (ins[31:26] == 6'd0 && ins[5:0] == 6'd8)        return jr;
    return pc + 32'd4;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] ins, logic [31:0] a, logic [31:0] b, logic [31:0] jr,
                      logic stl, logic rs, string tag);
    logic [31:0] e;
    @(negedge clk);
    instr_i = ins; cmp_a_i = a; cmp_b_i = b; jreg_i = jr; stall_i = stl; rst = rs;
    #1;
    check({tag, " link R3"}, pc_plus4_o, mpc + 32'd4);
    check({tag, " taken R10"}, {31'd0, br_taken_o}, {31'd0, exp_taken(ins, a, b)});
    if (rs)       e = RV;
    else if (stl) e = mpc;
    else          e = model_next(mpc, ins, a, b, jr);
    sb.push_back('{e, tag});
    mpc = e;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      check({it.tag, " next pc"}, pc_o, it.exp);
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset vector", pc_o, RV);
    mpc = RV;
    step({6'd8, 5'd22, 5'd21, 16'hFFCE}, 0, 0, 0, 0, 0, "R2 immediate op");
    step({6'd4, 5'd9, 5'd0, 16'd3}, 32'd7, 32'd7, 0, 0, 0, "R4 beq taken");
    step({6'd4, 5'd9, 5'd0, 16'd3}, 32'd7, 32'd8, 0, 0, 0, "R4 beq not taken");
    step({6'd5, 5'd1, 5'd2, 16'hFFFE}, 32'd1, 32'd2, 0, 0, 0, "R5 R6 bne back two");
    step({6'd5, 5'd1, 5'd2, 16'hFFFE}, 32'd5, 32'd5, 0, 0, 0, "R5 bne not taken");
    step({6'd4, 5'd0, 5'd0, 16'h8000}, 0, 0, 0, 0, 0, "R6 most negative offset");
    step({6'd2, 26'h010_0001}, 0, 0, 0, 0, 0, "R7 jump");
    step({6'd0, 5'd9, 15'd0, 6'd8}, 0, 0, 32'hA000_0010, 0, 0, "R8 register jump");
    step({6'd3, 26'h3FF_FFFF}, 0, 0, 0, 0, 0, "R7 jal region");
    step({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'h20}, 0, 0, 32'h1234_5678, 0, 0, "R2 R-type add");
    step({6'd2, 26'h000_0040}, 0, 0, 0, 1, 0, "R9 stall on jump");
    step({6'd4, 5'd0, 5'd0, 16'd9}, 32'd3, 32'd3, 0, 1, 0, "R9 stall on taken branch");
    step({6'h3F, 26'h155_5555}, 0, 0, 0, 0, 0, "R2 unknown opcode");
    step({6'd0, 5'd9, 15'd0, 6'd9}, 0, 0, 32'hDEAD_BEE0, 0, 0, "R2 opcode0 other funct");
    step({6'd2, 26'h000_0040}, 0, 0, 0, 1, 1, "R1 reset over stall");
    step({6'd0, 26'd0}, 0, 0, 0, 0, 0, "R2 after reset");
    @(negedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule